// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits between a synchronous requester and an asynchronous parallel NOR-style memory that offers page-mode reads. A request carries a word address and a one-cycle strobe. The block drives the memory's address bus and control pins, waits a programmable number of system clocks, and captures the 32-bit data bus. It then returns the word with a single-cycle valid pulse.

The memory reads internally in aligned groups of four words. The two lowest word-address bits select a word within the group. The block remembers the group that is open. When a read falls inside that group, the block uses the short page wait. Any other read uses the full random-access wait, and that read opens its own group. Chip enable stays asserted while a group is open, so consecutive hits change only the low address bits. After a run of idle cycles the block deasserts chip enable and forgets the group.

The address latch pin is tied to its transparent level, because page reads must not use latch-controlled addressing. The memory drives its outputs only while output enable is low and output disable is high. The block asserts that pair only during an access.

Top module: `page_flash_rd`

## Requirements
- R1: While reset is asserted and immediately after it, chip enable and output enable are high (inactive), the output-disable pin is low (outputs disabled), rdata_valid_o is low and idle_o is high.
- R2: A request is accepted on a clock edge only when idle_o is high. A request strobed while idle_o is low is ignored: the address, the timing and the returned data do not change.
- R3: A read to a closed or different group waits max(full_wait_i,1) cycles. If a request is accepted on edge E, the word is captured from mem_data_i on edge E+max(full_wait_i,1), and rdata_valid_o is high for the cycle that follows that edge.
- R4: A read whose address bits above bit 1 match the open group is a hit. A hit waits max(page_wait_i,1) cycles, with the same edge arithmetic as R3.
- R5: A read to a different group uses the full wait and makes its own group the open one, so the next read to that group is a hit.
- R6: A wait value of 0 behaves exactly like a wait value of 1.
- R7: mem_oe_no is low and mem_odis_no is high exactly while an access is in progress (from the accept edge to the capture edge). Outside an access, both are at their disabling levels.
- R8: mem_ce_no is low during every access and for as long as a group stays open. mem_addr_o holds the accepted address for the whole access.
- R9: If a group is open and the block is idle with no request for HOLD_CYC consecutive cycles, the group closes, mem_ce_no goes high, and the next read uses the full wait.
- R10: rdata_valid_o is high for one cycle per read. rdata_o keeps the last captured word until the next capture.
- R11: mem_le_no is held low at all times (transparent address latch).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read strobe, taken only while idle |
| addr_i | input | AW | Word address of the read |
| full_wait_i | input | CW | Random-access wait in clocks (0 treated as 1) |
| page_wait_i | input | CW | In-group wait in clocks (0 treated as 1) |
| idle_o | output | 1 | High when a request can be accepted |
| rdata_o | output | DW | Last word captured |
| rdata_valid_o | output | 1 | One-cycle pulse when rdata_o is new |
| mem_addr_o | output | AW | Memory address bus |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_odis_no | output | 1 | Memory output disable, active low (high lets outputs drive) |
| mem_le_no | output | 1 | Memory address latch, held low (transparent) |
| mem_data_i | input | DW | Memory data bus |

## Verification
A request accepted on edge E has its data due on edge E plus the effective wait: full for a miss and page for a hit, with 0 raised to 1. The valid pulse and the new rdata_o are visible in the cycle after that edge. The group closes on the HOLD_CYC-th consecutive idle edge without a request. A behavioural model in the bench advances on the same edges as the design. The bench compares every output at the falling edge, half a cycle after each update, so every result is checked in exactly the cycle it is due. The memory model drives a value derived from the address only while the output pins are enabled, so a capture at the wrong time or with the wrong address is visible as a data mismatch.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACC  = 1'b1
  } pfr_state_e;

  function automatic int unsigned pfr_cnt_w(input int unsigned hold);
    return (hold < 2) ? 1 : $clog2(hold + 1);
  endfunction
endpackage

// File: rtl/pfr_wait_ctr.sv
module pfr_wait_ctr #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          sel_page_i,
  input  logic [CW-1:0] full_i,
  input  logic [CW-1:0] page_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] raw, lim;

  assign raw = sel_page_i ? page_i : full_i;
  // zero programmed wait behaves as one
  assign lim = (raw == '0) ? CW'(1) : raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= lim;
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == CW'(1));

  assert_load_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/pfr_page_tag.sv
module pfr_page_tag #(
  parameter int TW       = 18,
  parameter int HOLD_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic [TW-1:0] tag_i,
  input  logic          idle_tick_i,
  output logic          hit_o,
  output logic          open_o
);
  localparam int HW = pfr_pkg::pfr_cnt_w(HOLD_CYC);

  logic          vld_q;
  logic [TW-1:0] tag_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      hold_q <= '0;
    end else if (open_i) begin
      vld_q  <= 1'b1;
      tag_q  <= tag_i;
      hold_q <= '0;
    end else if (idle_tick_i && vld_q) begin
      if (hold_q == HW'(HOLD_CYC - 1)) begin
        vld_q  <= 1'b0;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + HW'(1);
      end
    end
  end

  assign hit_o  = vld_q && (tag_q == tag_i);
  assign open_o = vld_q;

  assert_hold_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q < HW'(HOLD_CYC));
  assert_open_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> (open_o && tag_q == $past(tag_i)));
endmodule

// File: rtl/page_flash_rd.sv
module page_flash_rd
  import pfr_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 32,
  parameter int CW       = 6,
  parameter int HOLD_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] full_wait_i,
  input  logic [CW-1:0] page_wait_i,
  output logic          idle_o,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_odis_no,
  output logic          mem_le_no,
  input  logic [DW-1:0] mem_data_i
);
  localparam int TW = AW - 2;

  pfr_state_e    st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          valid_q;
  logic          accept, idle_tick, last, hit, pg_open, in_acc;

  assign in_acc    = (st_q == ST_ACC);
  assign accept    = !in_acc && req_i;
  assign idle_tick = !in_acc && !req_i;

  pfr_page_tag #(.TW(TW), .HOLD_CYC(HOLD_CYC)) u_tag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (accept),
    .tag_i      (addr_i[AW-1:2]),
    .idle_tick_i(idle_tick),
    .hit_o      (hit),
    .open_o     (pg_open)
  );

  pfr_wait_ctr #(.CW(CW)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .sel_page_i(hit),
    .full_i    (full_wait_i),
    .page_i    (page_wait_i),
    .last_o    (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_ACC;
          addr_q <= addr_i;
        end
        ST_ACC: if (last) begin
          rdata_q <= mem_data_i;
          valid_q <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o        = !in_acc;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = valid_q;
  assign mem_addr_o    = addr_q;
  assign mem_ce_no     = !(in_acc || pg_open);
  assign mem_oe_no     = !in_acc;
  assign mem_odis_no   = in_acc;
  assign mem_le_no     = 1'b0;

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o);
  assert_oe_needs_ce_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && mem_odis_no));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_acc && $past(in_acc)) |-> $stable(mem_addr_o));
  assert_busy_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && req_i && !last) |=> (!idle_o && $stable(mem_addr_o)));
  assert_capture_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_acc && last) |=> (rdata_valid_o && idle_o));
endmodule

// File: tb/page_flash_rd_tb_top.sv
module page_flash_rd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int CW = 6;
  localparam int HOLD = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] fw = CW'(5), pw = CW'(2);
  logic          idle, valid, ce_n, oe_n, odis_n, le_n;
  logic [DW-1:0] rdata, mdata;
  logic [AW-1:0] maddr;

  int n_cmp = 0, n_bad = 0;
  string phase = "R3";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return 32'hC0DE_0000 ^ ({12'h0, a} * 32'h0000_9E37);
  endfunction

  assign mdata = (!oe_n && odis_n && !ce_n) ? mem_word(maddr) : 32'hBAD0_BAD0;

  page_flash_rd #(.AW(AW), .DW(DW), .CW(CW), .HOLD_CYC(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .full_wait_i(fw), .page_wait_i(pw), .idle_o(idle), .rdata_o(rdata),
    .rdata_valid_o(valid), .mem_addr_o(maddr), .mem_ce_no(ce_n),
    .mem_oe_no(oe_n), .mem_odis_no(odis_n), .mem_le_no(le_n), .mem_data_i(mdata)
  );

  // behavioural reference
  bit            m_busy, m_tagv, m_valid;
  int            m_cnt, m_idle;
  logic [AW-1:0] m_addr;
  logic [AW-3:0] m_tag;
  logic [DW-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_tagv = 0; m_valid = 0; m_cnt = 0; m_idle = 0;
      m_addr = '0; m_tag = '0; m_data = '0;
    end else begin
      m_valid = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_data = mem_word(m_addr); m_valid = 1; m_busy = 0;
        end else m_cnt--;
      end else if (req) begin
        int w;
        w = (m_tagv && m_tag == addr[AW-1:2]) ? int'(pw) : int'(fw);
        m_cnt = (w == 0) ? 1 : w;
        m_busy = 1; m_addr = addr; m_tag = addr[AW-1:2]; m_tagv = 1; m_idle = 0;
      end else if (m_tagv) begin
        m_idle++;
        if (m_idle == HOLD) begin m_tagv = 0; m_idle = 0; end
      end
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 idle", {31'b0, idle}, {31'b0, !m_busy});
    chk("R7 oe", {31'b0, oe_n}, {31'b0, !m_busy});
    chk("R7 odis", {31'b0, odis_n}, {31'b0, m_busy});
    chk("R8/R9 ce", {31'b0, ce_n}, {31'b0, !(m_busy || m_tagv)});
    chk("R8 addr", {12'b0, maddr}, {12'b0, m_addr});
    chk({phase, " valid"}, {31'b0, valid}, {31'b0, m_valid});
    chk("R10 rdata", rdata, m_data);
    chk("R11 le", {31'b0, le_n}, 32'b0);
  end

  task automatic rd(input logic [AW-1:0] a);
    while (!idle) @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce", {31'b0, ce_n}, 32'd1);
    chk("R1 oe", {31'b0, oe_n}, 32'd1);
    chk("R1 odis", {31'b0, odis_n}, 32'd0);
    chk("R1 valid", {31'b0, valid}, 32'd0);
    chk("R1 idle", {31'b0, idle}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R3"; rd(20'h00100);
    phase = "R4"; rd(20'h00101); rd(20'h00103); rd(20'h00102);
    phase = "R5"; rd(20'h00200); rd(20'h00201);
    phase = "R2";
    while (!idle) @(negedge clk);
    req = 1'b1; addr = 20'h00300;
    @(negedge clk);
    addr = 20'h00777;   // strobe held while busy: ignored
    @(negedge clk); @(negedge clk);
    req = 1'b0;
    rd(20'h00301);
    phase = "R9"; idle_n(HOLD + 3); rd(20'h00302); rd(20'h00303);
    idle_n(HOLD - 2); rd(20'h00300);
    phase = "R6"; fw = '0; pw = '0; rd(20'h00500); rd(20'h00501); rd(20'h00601);
    phase = "R4"; fw = CW'(1); pw = CW'(3); rd(20'h00700); rd(20'h00702);
    idle_n(HOLD + 4);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule